// File: doc/BRIEF.md
# Scaled Fixed-Point Radix-2 Butterfly

This block performs one complex radix-2 butterfly per clock on 16-bit signed two's-complement data. Each accepted operand set holds two complex points A and B and a complex twiddle W. The block forms the product W·B from four full-width 16x16 real multiplies. It then produces the pair X = A + W·B and Y = A − W·B and scales both down by a shift chosen per operand set, so that a cascade of transform stages never leaves the 16-bit range.

The pipeline has three registered stages: multiply, combine and scale. A new operand set may enter on every cycle. The shift select is carried through the pipeline with its own operands. A controller can therefore run a fixed two-bit schedule, or mix one-bit and two-bit stages (for example 2, 1, 1, 1, repeated), with no gap between operand sets. Twiddle generation, data ordering and control of the whole transform sit outside this block.

Top module: `fxp_butterfly`

## Requirements
- R1: `out_valid` equals `in_valid` delayed by exactly three clock cycles, and each result appears in that same cycle.
- R2: Each of the four products Bre·Wre, Bim·Wim, Bre·Wim and Bim·Wre is kept at 32 bits and then arithmetically shifted right by 15. The real part of W·B is (Bre·Wre>>>15) − (Bim·Wim>>>15), the imaginary part is (Bre·Wim>>>15) + (Bim·Wre>>>15), and X = A + W·B, formed at 18 bits before scaling.
- R3: Y = A − W·B, formed at 18 bits before scaling, with the same W·B as in R2.
- R4: When `shift_one` is 0, each component of X and Y is the 18-bit intermediate shifted right arithmetically by two bits.
- R5: When `shift_one` is 1, each component of X and Y is the 18-bit intermediate shifted right arithmetically by one bit.
- R6: Discarded low bits are truncated with no rounding, so the result rounds toward minus infinity and keeps its sign. For example −1 stays −1 and −5 becomes −2 under a two-bit shift.
- R7: A shifted value above 32767 is output as 32767, and one below −32768 is output as −32768.
- R8: While `rst_n` is low, and in the first cycles after it rises, `out_valid` is 0 and all outputs are 0.
- R9: Operand sets presented on consecutive cycles produce results on consecutive cycles, each result computed only from its own operands.
- R10: The shift select is taken with its own operand set, so adjacent operand sets with different shift selects are each scaled by their own amount.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand set present this cycle |
| shift_one | input | 1 | 1: scale by one bit, 0: scale by two bits |
| a_re | input | 16 | Point A, real part |
| a_im | input | 16 | Point A, imaginary part |
| b_re | input | 16 | Point B, real part |
| b_im | input | 16 | Point B, imaginary part |
| w_re | input | 16 | Twiddle, real part (Q15) |
| w_im | input | 16 | Twiddle, imaginary part (Q15) |
| out_valid | output | 1 | Result present this cycle |
| x_re | output | 16 | Sum output, real part |
| x_im | output | 16 | Sum output, imaginary part |
| y_re | output | 16 | Difference output, real part |
| y_im | output | 16 | Difference output, imaginary part |

## Verification
The bench drives operands at both ends of the range, where full-scale products renormalise to +32768 and the sum needs the two guard bits. A design that dropped a guard bit would wrap sign there, and one that clamped the wrong way would saturate to the opposite rail. Small negative values under both shift amounts expose a design that rounds, or that shifts logically and turns −1 into a large positive number. Back-to-back operand sets with alternating shift selects catch a design that samples the shift select at the wrong stage and scales a neighbour's result. A valid pattern with gaps catches a latency that is off by one cycle.

// File: rtl/bfly_pkg.sv
package bfly_pkg;

    localparam int unsigned BF_DATA_W  = 16;
    localparam int unsigned BF_FRAC_W  = 15;
    localparam int unsigned BF_GUARD_W = 2;

    typedef enum logic {
        SCALE_QUARTER = 1'b0,
        SCALE_HALF    = 1'b1
    } scale_e;

endpackage

// File: rtl/bfly_mul.sv
module bfly_mul
    import bfly_pkg::*;
#(
    parameter int unsigned DW = BF_DATA_W,
    localparam int unsigned PW = 2 * DW
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 vld_i,
    input  scale_e               scale_i,
    input  logic signed [DW-1:0] a_re_i,
    input  logic signed [DW-1:0] a_im_i,
    input  logic signed [DW-1:0] b_re_i,
    input  logic signed [DW-1:0] b_im_i,
    input  logic signed [DW-1:0] w_re_i,
    input  logic signed [DW-1:0] w_im_i,
    output logic                 vld_o,
    output scale_e               scale_o,
    output logic signed [DW-1:0] a_re_o,
    output logic signed [DW-1:0] a_im_o,
    output logic signed [PW-1:0] prod_o [4]
);

    // product k uses lhs[k] * rhs[k]: rr, ii, ri, ir
    logic signed [DW-1:0] lhs [4];
    logic signed [DW-1:0] rhs [4];

    always_comb begin
        lhs[0] = b_re_i; rhs[0] = w_re_i;
        lhs[1] = b_im_i; rhs[1] = w_im_i;
        lhs[2] = b_re_i; rhs[2] = w_im_i;
        lhs[3] = b_im_i; rhs[3] = w_re_i;
    end

    for (genvar k = 0; k < 4; k++) begin : g_prod
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                prod_o[k] <= '0;
            end else if (vld_i) begin
                prod_o[k] <= lhs[k] * rhs[k];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld_o   <= 1'b0;
            scale_o <= SCALE_QUARTER;
            a_re_o  <= '0;
            a_im_o  <= '0;
        end else begin
            vld_o <= vld_i;
            if (vld_i) begin
                scale_o <= scale_i;
                a_re_o  <= a_re_i;
                a_im_o  <= a_im_i;
            end
        end
    end

endmodule

// File: rtl/bfly_combine.sv
module bfly_combine
    import bfly_pkg::*;
#(
    parameter int unsigned DW = BF_DATA_W,
    parameter int unsigned FW = BF_FRAC_W,
    parameter int unsigned GW = BF_GUARD_W,
    localparam int unsigned PW = 2 * DW,
    localparam int unsigned CW = DW + GW
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 vld_i,
    input  scale_e               scale_i,
    input  logic signed [DW-1:0] a_re_i,
    input  logic signed [DW-1:0] a_im_i,
    input  logic signed [PW-1:0] prod_i [4],
    output logic                 vld_o,
    output scale_e               scale_o,
    output logic signed [CW-1:0] res_o [4]
);

    logic signed [CW-1:0] renorm [4];
    logic signed [CW-1:0] wb_re, wb_im, a_re_x, a_im_x;
    logic signed [CW-1:0] nxt [4];

    always_comb begin
        for (int k = 0; k < 4; k++) begin
            renorm[k] = CW'(prod_i[k] >>> FW);
        end
        wb_re  = renorm[0] - renorm[1];
        wb_im  = renorm[2] + renorm[3];
        a_re_x = CW'(a_re_i);
        a_im_x = CW'(a_im_i);
        nxt[0] = a_re_x + wb_re;
        nxt[1] = a_im_x + wb_im;
        nxt[2] = a_re_x - wb_re;
        nxt[3] = a_im_x - wb_im;
    end

    for (genvar k = 0; k < 4; k++) begin : g_res
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                res_o[k] <= '0;
            end else if (vld_i) begin
                res_o[k] <= nxt[k];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld_o   <= 1'b0;
            scale_o <= SCALE_QUARTER;
        end else begin
            vld_o <= vld_i;
            if (vld_i) begin
                scale_o <= scale_i;
            end
        end
    end

    // R3: sum and difference of one butterfly always add up to twice A
    pair_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vld_o |-> ({res_o[0][CW-1], res_o[0]} + {res_o[2][CW-1], res_o[2]})
                  == {{(CW-DW){$past(a_re_i[DW-1])}}, $past(a_re_i), 1'b0});

endmodule

// File: rtl/bfly_scale_lane.sv
module bfly_scale_lane
    import bfly_pkg::*;
#(
    parameter int unsigned DW = BF_DATA_W,
    parameter int unsigned GW = BF_GUARD_W,
    localparam int unsigned CW = DW + GW
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 vld_i,
    input  scale_e               scale_i,
    input  logic signed [CW-1:0] val_i,
    output logic signed [DW-1:0] res_o
);

    localparam logic signed [CW-1:0] HI = CW'(2 ** (DW - 1) - 1);
    localparam logic signed [CW-1:0] LO = CW'(-(2 ** (DW - 1)));

    logic signed [CW-1:0] shifted;
    logic signed [DW-1:0] clamped;

    always_comb begin
        unique case (scale_i)
            SCALE_HALF:    shifted = val_i >>> 1;
            SCALE_QUARTER: shifted = val_i >>> 2;
            default:       shifted = val_i >>> 2;
        endcase
        if (shifted > HI) begin
            clamped = DW'(HI);
        end else if (shifted < LO) begin
            clamped = DW'(LO);
        end else begin
            clamped = shifted[DW-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_o <= '0;
        end else if (vld_i) begin
            res_o <= clamped;
        end
    end

    // R6
    sign_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vld_i |=> (res_o[DW-1] == $past(val_i[CW-1])));

    // R7
    sat_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_i && scale_i == SCALE_HALF && val_i[CW-1:CW-2] == 2'b01)
        |=> (res_o == DW'(HI)));

endmodule

// File: rtl/fxp_butterfly.sv
module fxp_butterfly
    import bfly_pkg::*;
#(
    parameter int unsigned DW = BF_DATA_W,
    parameter int unsigned FW = BF_FRAC_W,
    parameter int unsigned GW = BF_GUARD_W,
    localparam int unsigned PW = 2 * DW,
    localparam int unsigned CW = DW + GW
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic                 shift_one,
    input  logic signed [DW-1:0] a_re,
    input  logic signed [DW-1:0] a_im,
    input  logic signed [DW-1:0] b_re,
    input  logic signed [DW-1:0] b_im,
    input  logic signed [DW-1:0] w_re,
    input  logic signed [DW-1:0] w_im,
    output logic                 out_valid,
    output logic signed [DW-1:0] x_re,
    output logic signed [DW-1:0] x_im,
    output logic signed [DW-1:0] y_re,
    output logic signed [DW-1:0] y_im
);

    logic                 mul_vld, cmb_vld;
    scale_e               mul_scale, cmb_scale;
    logic signed [DW-1:0] mul_a_re, mul_a_im;
    logic signed [PW-1:0] mul_prod [4];
    logic signed [CW-1:0] cmb_res [4];
    logic signed [DW-1:0] lane_out [4];

    bfly_mul #(.DW(DW)) u_mul (
        .clk     (clk),
        .rst_n   (rst_n),
        .vld_i   (in_valid),
        .scale_i (scale_e'(shift_one)),
        .a_re_i  (a_re),
        .a_im_i  (a_im),
        .b_re_i  (b_re),
        .b_im_i  (b_im),
        .w_re_i  (w_re),
        .w_im_i  (w_im),
        .vld_o   (mul_vld),
        .scale_o (mul_scale),
        .a_re_o  (mul_a_re),
        .a_im_o  (mul_a_im),
        .prod_o  (mul_prod)
    );

    bfly_combine #(.DW(DW), .FW(FW), .GW(GW)) u_combine (
        .clk     (clk),
        .rst_n   (rst_n),
        .vld_i   (mul_vld),
        .scale_i (mul_scale),
        .a_re_i  (mul_a_re),
        .a_im_i  (mul_a_im),
        .prod_i  (mul_prod),
        .vld_o   (cmb_vld),
        .scale_o (cmb_scale),
        .res_o   (cmb_res)
    );

    for (genvar k = 0; k < 4; k++) begin : g_lane
        bfly_scale_lane #(.DW(DW), .GW(GW)) u_lane (
            .clk     (clk),
            .rst_n   (rst_n),
            .vld_i   (cmb_vld),
            .scale_i (cmb_scale),
            .val_i   (cmb_res[k]),
            .res_o   (lane_out[k])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
        end else begin
            out_valid <= cmb_vld;
        end
    end

    always_comb begin
        x_re = lane_out[0];
        x_im = lane_out[1];
        y_re = lane_out[2];
        y_im = lane_out[3];
    end

    // cycles since reset, saturating, for the latency check
    logic [1:0] since_rst;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_rst <= '0;
        end else if (since_rst != 2'd3) begin
            since_rst <= since_rst + 2'd1;
        end
    end

    // R1
    valid_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 2'd3) |-> (out_valid == $past(in_valid, 3)));

    // R8
    always @(negedge clk) begin
        if (!rst_n) begin
            reset_quiet_chk: assert (!out_valid && x_re == '0 && x_im == '0
                                     && y_re == '0 && y_im == '0);
        end
    end

endmodule

// File: tb/test_fxp_butterfly.sv
module test_fxp_butterfly;

    logic clk = 1'b0;
    logic rst_n = 1'b1;
    logic in_valid = 1'b0;
    logic shift_one = 1'b0;
    logic signed [15:0] a_re = '0, a_im = '0, b_re = '0, b_im = '0, w_re = '0, w_im = '0;
    logic out_valid;
    logic signed [15:0] x_re, x_im, y_re, y_im;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    int    q_v[$], q_xr[$], q_xi[$], q_yr[$], q_yi[$];
    string q_tag[$];

    always #10 clk = ~clk;

    fxp_butterfly i_fxp_butterfly (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .shift_one(shift_one),
        .a_re(a_re), .a_im(a_im), .b_re(b_re), .b_im(b_im), .w_re(w_re), .w_im(w_im),
        .out_valid(out_valid), .x_re(x_re), .x_im(x_im), .y_re(y_re), .y_im(y_im)
    );

    function automatic int clamp16(int v);
        if (v > 32767) return 32767;
        if (v < -32768) return -32768;
        return v;
    endfunction

    task automatic check_outputs();
        int ev, exr, exi, eyr, eyi;
        string tg;
        if (q_v.size() < 3) begin
            checks++;
            if (out_valid !== 1'b0 || x_re !== 0 || x_im !== 0 || y_re !== 0 || y_im !== 0) begin
                failures++;
                $display("FAIL R8 after reset: actual v=%0b x=(%0d,%0d) y=(%0d,%0d) expected v=0 all zero",
                         out_valid, x_re, x_im, y_re, y_im);
            end
            return;
        end
        ev = q_v.pop_front(); exr = q_xr.pop_front(); exi = q_xi.pop_front();
        eyr = q_yr.pop_front(); eyi = q_yi.pop_front(); tg = q_tag.pop_front();
        checks++;
        if (out_valid !== ev[0]) begin
            failures++;
            $display("FAIL R1 valid latency: actual=%0b expected=%0b", out_valid, ev);
        end
        if (ev != 0) begin
            checks++;
            if (x_re != exr || x_im != exi || y_re != eyr || y_im != eyi) begin
                failures++;
                $display("FAIL %s data: actual x=(%0d,%0d) y=(%0d,%0d) expected x=(%0d,%0d) y=(%0d,%0d)",
                         tg, x_re, x_im, y_re, y_im, exr, exi, eyr, eyi);
            end
        end
    endtask

    task automatic step(input bit v, input bit s1, input int ar, input int ai,
                        input int br, input int bi, input int wr, input int wi,
                        input string tg);
        int rr, ii, ri, ir, wbr, wbi, sh;
        @(negedge clk);
        check_outputs();
        in_valid  = v;
        shift_one = s1;
        a_re = 16'(ar); a_im = 16'(ai); b_re = 16'(br);
        b_im = 16'(bi); w_re = 16'(wr); w_im = 16'(wi);
        rr = (br * wr) >>> 15;
        ii = (bi * wi) >>> 15;
        ri = (br * wi) >>> 15;
        ir = (bi * wr) >>> 15;
        wbr = rr - ii;
        wbi = ri + ir;
        sh = s1 ? 1 : 2;
        q_v.push_back(v ? 1 : 0);
        q_xr.push_back(clamp16((ar + wbr) >>> sh));
        q_xi.push_back(clamp16((ai + wbi) >>> sh));
        q_yr.push_back(clamp16((ar - wbr) >>> sh));
        q_yi.push_back(clamp16((ai - wbi) >>> sh));
        q_tag.push_back(tg);
    endtask

    function automatic int rnd16();
        logic [15:0] r;
        r = 16'($urandom());
        return int'($signed(r));
    endfunction

    initial begin
        void'($urandom(32'd11));
        #1 rst_n = 1'b0;
        repeat (3) @(negedge clk);
        // R8: reset state while reset is held
        checks++;
        if (out_valid !== 1'b0 || x_re !== 0 || y_re !== 0) begin
            failures++;
            $display("FAIL R8 in reset: actual v=%0b x_re=%0d y_re=%0d expected 0", out_valid, x_re, y_re);
        end
        rst_n = 1'b1;

        // R2: X = A + W*B, real twiddle just below one
        step(1, 0, 100, -200, 16384, 0, 32767, 0, "R2");
        // R3: difference with complex twiddle
        step(1, 0, 1000, 500, 8000, -4000, 0, 32767, "R3");
        step(0, 0, 0, 0, 0, 0, 0, 0, "R1");
        // R4: two-bit scaling of a plain value
        step(1, 0, 4000, -4000, 0, 0, 0, 0, "R4");
        // R5: one-bit scaling of the same value
        step(1, 1, 4000, -4000, 0, 0, 0, 0, "R5");
        // R6: truncation toward minus infinity
        step(1, 0, -1, -5, 0, 0, 0, 0, "R6");
        step(1, 1, -1, -3, 0, 0, 0, 0, "R6");
        // R7: positive and negative saturation at one-bit scaling
        step(1, 1, 32767, 32767, -32768, -32768, -32768, -32768, "R7");
        step(1, 1, 32767, -32768, -32768, -32768, -32768, -32768, "R7");
        // R2: same extreme operands at two-bit scaling fit with guard bits
        step(1, 0, 32767, 32767, -32768, -32768, -32768, -32768, "R2");
        step(0, 0, 0, 0, 0, 0, 0, 0, "R1");
        step(0, 0, 0, 0, 0, 0, 0, 0, "R1");
        // R10: alternating shift select on back-to-back identical operands
        for (int i = 0; i < 6; i++) begin
            step(1, i[0], 20001, -19999, 12345, -23456, 23170, -23170, "R10");
        end
        // R9: continuous and gapped random traffic
        for (int i = 0; i < 300; i++) begin
            step((i < 100) ? 1'b1 : ($urandom_range(3, 0) != 0), 1'($urandom()),
                 rnd16(), rnd16(), rnd16(), rnd16(), rnd16(), rnd16(), "R9");
        end
        for (int i = 0; i < 4; i++) begin
            step(0, 0, 0, 0, 0, 0, 0, 0, "R1");
        end
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL R1 watchdog: actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule